// File: doc/BRIEF.md
# SIMD Element Indexed Operand Unit

This block forms the operands for one processing element in a lock-step SIMD array. Every element receives the same instruction variant code and the same 64-bit broadcast word from the central controller. Each element also holds a private index register, so one broadcast instruction can produce different addresses, shift distances and bit numbers in different elements. Software can load that register from the element's hard-wired number, which turns a shared address into a per-element skewed address. It can also load it from the local datapath, for example with a normalization correction.

The variant code selects how the broadcast word is read. It can be a 64-bit literal, a 16-bit local-memory address, a 16-bit register selector, or a shift distance. When the distance drives the built-in 128-bit double-length shifter, it is counted in bits. The same operation can instead work on a single bit of a 64-bit word, where it sets, clears, complements or tests that bit. The address, shift and bit-number paths can each add the index register. The register-selector path never does.

All operand outputs are combinational from the inputs and the index register. The index register is the only state in the block.

Top module: `pe_operand_unit`

## Requirements
- R1: With variant code 0 (literal), `literal_o` equals all 64 bits of `bcast_i` unmodified.
- R2: With variant code 1 (address), `addr_o` is `bcast_i[15:0]`. When `use_idx_i` is 1, the full 16-bit index register is added, and the sum wraps modulo 2^16 with no carry reported.
- R3: With variant code 2 (register), `reg_sel_o` equals `bcast_i[15:0]`, whatever the value of `use_idx_i`.
- R4: With variant code 3 (shift), `shift_dist_o` is `bcast_i[6:0]`. When `use_idx_i` is 1, the index register's low 7 bits are added, and the sum is taken modulo 128.
- R5: With variant code 3, `{shift_hi_o, shift_lo_o}` is `{opnd_hi_i, opnd_lo_i}` shifted by `shift_dist_o` with zero fill. The shift is to the left when `shift_left_i` is 1 and to the right otherwise.
- R6: With variant code 4 (bit operation), the bit number is `bcast_i[5:0]`. When `use_idx_i` is 1, the index register's low 6 bits are added, and the sum is taken modulo 64. `bit_op_i` codes 0, 1 and 2 then drive `bit_word_o` to `opnd_lo_i` with that bit set, cleared or complemented, and `bit_flag_o` stays 0.
- R7: With variant code 4 and `bit_op_i` code 3 (test), `bit_flag_o` equals the selected bit of `opnd_lo_i`, and `bit_word_o` equals `opnd_lo_i` unchanged.
- R8: The index register, seen on `idx_o`, resets to 0. When `idx_load_i` is 1, the register loads on the next rising clock edge: from the element number `PE_ID` when `idx_src_i` is 0, or from `idx_data_i` when `idx_src_i` is 1. With no load it holds its value.
- R9: Every operand output that does not belong to the current variant is 0. Variant codes 5 to 7 drive all operand outputs to 0.
- R10: The array size `NUM_PE` may be 8, 16, 32 or 64. The element number is `$clog2(NUM_PE)` bits wide and is zero-extended into the index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| variant_i | input | 3 | Broadcast variant code (0 literal, 1 address, 2 register, 3 shift, 4 bit operation) |
| use_idx_i | input | 1 | Add the index register to the address, shift distance or bit number |
| bcast_i | input | 64 | Broadcast common data word |
| opnd_lo_i | input | 64 | Local word; low half of the shifter input, and the target of bit operations |
| opnd_hi_i | input | 64 | Local word; high half of the shifter input |
| shift_left_i | input | 1 | 1 selects a left shift, 0 a right shift |
| bit_op_i | input | 2 | 0 set, 1 clear, 2 complement, 3 test |
| idx_load_i | input | 1 | Load the index register on the next edge |
| idx_src_i | input | 1 | Load source: 0 element number, 1 `idx_data_i` |
| idx_data_i | input | 16 | Index value from the local datapath |
| literal_o | output | 64 | Literal operand |
| addr_o | output | 16 | Effective local-memory address |
| reg_sel_o | output | 16 | Register selector |
| shift_dist_o | output | 7 | Effective shift distance |
| shift_lo_o | output | 64 | Shifted result, low word |
| shift_hi_o | output | 64 | Shifted result, high word |
| bit_word_o | output | 64 | Word after the bit operation |
| bit_flag_o | output | 1 | Result of the bit test |
| idx_o | output | 16 | Current index register value |

## Verification
The bench first drives the address variant with indexing off and then on, after loading the index register from the element number and later from datapath data. This separates the plain broadcast address from the skewed per-element address, and the sum FFFF plus an index exposes any missing 16-bit wrap. Shift distances of 0 and 127, a sum that passes 128, and both directions separate the modulo-128 count from a truncated or saturated count, and left-shift faults from right-shift faults. Bit numbers that cross 63, each of the four bit operations, and the register variant with indexing requested all isolate a single decode path. Unused variant codes and a long stretch of random vectors then catch leakage between the output groups.

// File: rtl/pe_opnd_pkg.sv
package pe_opnd_pkg;
  typedef enum logic [2:0] {
    VAR_LIT   = 3'd0,
    VAR_ADDR  = 3'd1,
    VAR_REG   = 3'd2,
    VAR_SHIFT = 3'd3,
    VAR_BIT   = 3'd4
  } variant_e;

  typedef enum logic [1:0] {
    BOP_SET  = 2'd0,
    BOP_CLR  = 2'd1,
    BOP_CMP  = 2'd2,
    BOP_TEST = 2'd3
  } bit_op_e;
endpackage

// File: rtl/pe_index_reg.sv
module pe_index_reg #(
  parameter int IDX_W = 16,
  parameter int ID_W  = 6,
  parameter int PE_ID = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             src_i,
  input  logic [IDX_W-1:0] data_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [ID_W-1:0] ElemNum = ID_W'(PE_ID);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (load_i) idx_q <= src_i ? data_i : IDX_W'(ElemNum);
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/pe_idx_add.sv
module pe_idx_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] idx_i,
  input  logic         en_i,
  output logic [W-1:0] sum_o
);
  // carry out dropped on purpose: modulo 2^W
  assign sum_o = base_i + (en_i ? idx_i : '0);
endmodule

// File: rtl/pe_dbl_shifter.sv
module pe_dbl_shifter #(
  parameter int W      = 64,
  parameter int DIST_W = 7
) (
  input  logic [W-1:0]      lo_i,
  input  logic [W-1:0]      hi_i,
  input  logic [DIST_W-1:0] dist_i,
  input  logic              left_i,
  output logic [W-1:0]      lo_o,
  output logic [W-1:0]      hi_o
);
  localparam int TW = 2 * W;

  function automatic logic [TW-1:0] bit_rev(input logic [TW-1:0] v);
    logic [TW-1:0] r;
    for (int i = 0; i < TW; i++) r[i] = v[TW-1-i];
    return r;
  endfunction

  logic [TW-1:0] stg [DIST_W+1];
  logic [TW-1:0] res;

  // right shift = reverse, shift left, reverse
  assign stg[0] = left_i ? {hi_i, lo_i} : bit_rev({hi_i, lo_i});

  for (genvar s = 0; s < DIST_W; s++) begin : g_stage
    assign stg[s+1] = dist_i[s] ? (stg[s] << (2 ** s)) : stg[s];
  end

  assign res  = left_i ? stg[DIST_W] : bit_rev(stg[DIST_W]);
  assign lo_o = res[W-1:0];
  assign hi_o = res[TW-1:W];
endmodule

// File: rtl/pe_bit_unit.sv
module pe_bit_unit
  import pe_opnd_pkg::*;
#(
  parameter int W     = 64,
  parameter int BIT_W = 6
) (
  input  logic [W-1:0]     word_i,
  input  logic [BIT_W-1:0] bit_num_i,
  input  logic [1:0]       op_i,
  output logic [W-1:0]     word_o,
  output logic             flag_o
);
  logic [W-1:0] mask;
  bit_op_e      op;

  assign op   = bit_op_e'(op_i);
  assign mask = W'(1) << bit_num_i;

  always_comb begin
    flag_o = 1'b0;
    unique case (op)
      BOP_SET:  word_o = word_i | mask;
      BOP_CLR:  word_o = word_i & ~mask;
      BOP_CMP:  word_o = word_i ^ mask;
      default: begin
        word_o = word_i;
        flag_o = word_i[bit_num_i];
      end
    endcase
  end
endmodule

// File: rtl/pe_operand_unit.sv
module pe_operand_unit
  import pe_opnd_pkg::*;
#(
  parameter int NUM_PE = 64,
  parameter int PE_ID  = 0,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [2:0]                  variant_i,
  input  logic                        use_idx_i,
  input  logic [DATA_W-1:0]           bcast_i,
  input  logic [DATA_W-1:0]           opnd_lo_i,
  input  logic [DATA_W-1:0]           opnd_hi_i,
  input  logic                        shift_left_i,
  input  logic [1:0]                  bit_op_i,
  input  logic                        idx_load_i,
  input  logic                        idx_src_i,
  input  logic [IDX_W-1:0]            idx_data_i,
  output logic [DATA_W-1:0]           literal_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic [ADDR_W-1:0]           reg_sel_o,
  output logic [$clog2(2*DATA_W)-1:0] shift_dist_o,
  output logic [DATA_W-1:0]           shift_lo_o,
  output logic [DATA_W-1:0]           shift_hi_o,
  output logic [DATA_W-1:0]           bit_word_o,
  output logic                        bit_flag_o,
  output logic [IDX_W-1:0]            idx_o
);
  localparam int ID_W   = $clog2(NUM_PE);
  localparam int DIST_W = $clog2(2 * DATA_W);
  localparam int BIT_W  = $clog2(DATA_W);

  variant_e         var_sel;
  logic [IDX_W-1:0] idx_q;
  logic [ADDR_W-1:0] addr_eff;
  logic [DIST_W-1:0] dist_eff;
  logic [BIT_W-1:0]  bit_eff;
  logic [DATA_W-1:0] sh_lo, sh_hi, bw;
  logic              bflag;

  assign var_sel = variant_e'(variant_i);

  pe_index_reg #(.IDX_W(IDX_W), .ID_W(ID_W), .PE_ID(PE_ID)) u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (idx_load_i),
    .src_i  (idx_src_i),
    .data_i (idx_data_i),
    .idx_o  (idx_q)
  );

  pe_idx_add #(.W(ADDR_W)) u_addr_add (
    .base_i (bcast_i[ADDR_W-1:0]),
    .idx_i  (ADDR_W'(idx_q)),
    .en_i   (use_idx_i),
    .sum_o  (addr_eff)
  );

  pe_idx_add #(.W(DIST_W)) u_dist_add (
    .base_i (bcast_i[DIST_W-1:0]),
    .idx_i  (idx_q[DIST_W-1:0]),
    .en_i   (use_idx_i),
    .sum_o  (dist_eff)
  );

  pe_idx_add #(.W(BIT_W)) u_bit_add (
    .base_i (bcast_i[BIT_W-1:0]),
    .idx_i  (idx_q[BIT_W-1:0]),
    .en_i   (use_idx_i),
    .sum_o  (bit_eff)
  );

  pe_dbl_shifter #(.W(DATA_W), .DIST_W(DIST_W)) u_shift (
    .lo_i   (opnd_lo_i),
    .hi_i   (opnd_hi_i),
    .dist_i (dist_eff),
    .left_i (shift_left_i),
    .lo_o   (sh_lo),
    .hi_o   (sh_hi)
  );

  pe_bit_unit #(.W(DATA_W), .BIT_W(BIT_W)) u_bit (
    .word_i    (opnd_lo_i),
    .bit_num_i (bit_eff),
    .op_i      (bit_op_i),
    .word_o    (bw),
    .flag_o    (bflag)
  );

  // per-variant output gating
  always_comb begin
    literal_o    = '0;
    addr_o       = '0;
    reg_sel_o    = '0;
    shift_dist_o = '0;
    shift_lo_o   = '0;
    shift_hi_o   = '0;
    bit_word_o   = '0;
    bit_flag_o   = 1'b0;
    unique case (var_sel)
      VAR_LIT:   literal_o = bcast_i;
      VAR_ADDR:  addr_o    = addr_eff;
      VAR_REG:   reg_sel_o = bcast_i[ADDR_W-1:0];
      VAR_SHIFT: begin
        shift_dist_o = dist_eff;
        shift_lo_o   = sh_lo;
        shift_hi_o   = sh_hi;
      end
      VAR_BIT: begin
        bit_word_o = bw;
        bit_flag_o = bflag;
      end
      default: ;
    endcase
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/pe_operand_unit_chk.sv
module pe_operand_unit_chk #(
  parameter int NUM_PE = 64,
  parameter int PE_ID  = 0,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [2:0]                  variant_i,
  input logic                        use_idx_i,
  input logic [DATA_W-1:0]           bcast_i,
  input logic [DATA_W-1:0]           opnd_lo_i,
  input logic [DATA_W-1:0]           opnd_hi_i,
  input logic                        shift_left_i,
  input logic [1:0]                  bit_op_i,
  input logic                        idx_load_i,
  input logic                        idx_src_i,
  input logic [IDX_W-1:0]            idx_data_i,
  input logic [DATA_W-1:0]           literal_o,
  input logic [ADDR_W-1:0]           addr_o,
  input logic [ADDR_W-1:0]           reg_sel_o,
  input logic [$clog2(2*DATA_W)-1:0] shift_dist_o,
  input logic [DATA_W-1:0]           shift_lo_o,
  input logic [DATA_W-1:0]           shift_hi_o,
  input logic [DATA_W-1:0]           bit_word_o,
  input logic                        bit_flag_o,
  input logic [IDX_W-1:0]            idx_o
);
  p_lit_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    variant_i == 3'd0 |-> literal_o == bcast_i);

  p_addr_noidx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (variant_i == 3'd1 && !use_idx_i) |-> addr_o == bcast_i[ADDR_W-1:0]);

  p_reg_noidx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    variant_i == 3'd2 |-> reg_sel_o == bcast_i[ADDR_W-1:0]);

  p_test_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (variant_i == 3'd4 && bit_op_i == 2'd3) |-> bit_word_o == opnd_lo_i);

  p_flag_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_flag_o |-> (variant_i == 3'd4 && bit_op_i == 2'd3));

  p_idx_elem_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_load_i && !idx_src_i) |=> idx_o == IDX_W'(PE_ID));

  p_idx_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_load_i && idx_src_i) |=> idx_o == $past(idx_data_i));

  p_idx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_load_i |=> $stable(idx_o));

  p_addr_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    variant_i != 3'd1 |-> addr_o == '0);

  p_shift_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    variant_i != 3'd3 |-> (shift_lo_o == '0 && shift_hi_o == '0 && shift_dist_o == '0));
endmodule

bind pe_operand_unit pe_operand_unit_chk #(
  .NUM_PE(NUM_PE), .PE_ID(PE_ID), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/pe_operand_unit_tb.sv
module pe_operand_unit_tb;
  localparam int NUM_PE = 64;
  localparam int PE_ID  = 37;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  variant_i = '0;
  logic        use_idx_i = 1'b0;
  logic [63:0] bcast_i = '0;
  logic [63:0] opnd_lo_i = '0;
  logic [63:0] opnd_hi_i = '0;
  logic        shift_left_i = 1'b0;
  logic [1:0]  bit_op_i = '0;
  logic        idx_load_i = 1'b0;
  logic        idx_src_i = 1'b0;
  logic [15:0] idx_data_i = '0;
  logic [63:0] literal_o, shift_lo_o, shift_hi_o, bit_word_o;
  logic [15:0] addr_o, reg_sel_o, idx_o;
  logic [6:0]  shift_dist_o;
  logic        bit_flag_o;

  int vectors = 0;
  int miscompares = 0;
  logic [15:0] m_idx = '0;

  always #5 clk_i = ~clk_i;

  pe_operand_unit #(.NUM_PE(NUM_PE), .PE_ID(PE_ID)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .variant_i(variant_i), .use_idx_i(use_idx_i),
    .bcast_i(bcast_i), .opnd_lo_i(opnd_lo_i), .opnd_hi_i(opnd_hi_i),
    .shift_left_i(shift_left_i), .bit_op_i(bit_op_i), .idx_load_i(idx_load_i),
    .idx_src_i(idx_src_i), .idx_data_i(idx_data_i), .literal_o(literal_o),
    .addr_o(addr_o), .reg_sel_o(reg_sel_o), .shift_dist_o(shift_dist_o),
    .shift_lo_o(shift_lo_o), .shift_hi_o(shift_hi_o), .bit_word_o(bit_word_o),
    .bit_flag_o(bit_flag_o), .idx_o(idx_o)
  );

  task automatic cmp(input string req, input string nm, input logic [127:0] act,
                     input logic [127:0] exp, inout bit bad);
    if (act !== exp) begin
      $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
      bad = 1'b1;
    end
  endtask

  // reference model: compare current outputs against requirement arithmetic
  task automatic check_now();
    bit          bad = 1'b0;
    int          v = int'(variant_i);
    int          a, d, n;
    logic [127:0] w, sw;
    logic [63:0] e_lit = '0, e_lo = '0, e_hi = '0, e_bw = '0;
    logic [15:0] e_addr = '0, e_reg = '0;
    logic [6:0]  e_dist = '0;
    logic        e_flag = 1'b0;
    if (v == 0) e_lit = bcast_i;
    if (v == 1) begin
      a = int'(bcast_i[15:0]) + (use_idx_i ? int'(m_idx) : 0);
      e_addr = 16'(a % 65536);
    end
    if (v == 2) e_reg = bcast_i[15:0];
    if (v == 3) begin
      d = int'(bcast_i[6:0]) + (use_idx_i ? int'(m_idx[6:0]) : 0);
      e_dist = 7'(d % 128);
      w = {opnd_hi_i, opnd_lo_i};
      sw = shift_left_i ? (w << (d % 128)) : (w >> (d % 128));
      e_hi = sw[127:64];
      e_lo = sw[63:0];
    end
    if (v == 4) begin
      n = (int'(bcast_i[5:0]) + (use_idx_i ? int'(m_idx[5:0]) : 0)) % 64;
      e_bw = opnd_lo_i;
      case (bit_op_i)
        2'd0: e_bw[n] = 1'b1;
        2'd1: e_bw[n] = 1'b0;
        2'd2: e_bw[n] = ~opnd_lo_i[n];
        default: e_flag = opnd_lo_i[n];
      endcase
    end
    vectors++;
    cmp("R1/R9", "literal_o", 128'(literal_o), 128'(e_lit), bad);
    cmp("R2/R9", "addr_o", 128'(addr_o), 128'(e_addr), bad);
    cmp("R3/R9", "reg_sel_o", 128'(reg_sel_o), 128'(e_reg), bad);
    cmp("R4/R9", "shift_dist_o", 128'(shift_dist_o), 128'(e_dist), bad);
    cmp("R5/R9", "shift_hi_o", 128'(shift_hi_o), 128'(e_hi), bad);
    cmp("R5/R9", "shift_lo_o", 128'(shift_lo_o), 128'(e_lo), bad);
    cmp("R6/R9", "bit_word_o", 128'(bit_word_o), 128'(e_bw), bad);
    cmp("R7/R9", "bit_flag_o", 128'(bit_flag_o), 128'(e_flag), bad);
    cmp("R8/R10", "idx_o", 128'(idx_o), 128'(m_idx), bad);
    if (bad) miscompares++;
  endtask

  // drive at negedge, check mid-phase, then model the load at the edge
  task automatic vec(input logic [2:0] v, input logic ui, input logic [63:0] b,
                     input logic [63:0] lo, input logic [63:0] hi, input logic left,
                     input logic [1:0] op, input logic ld, input logic src,
                     input logic [15:0] dat);
    @(negedge clk_i);
    variant_i = v; use_idx_i = ui; bcast_i = b; opnd_lo_i = lo; opnd_hi_i = hi;
    shift_left_i = left; bit_op_i = op; idx_load_i = ld; idx_src_i = src; idx_data_i = dat;
    #2;
    check_now();
    @(posedge clk_i);
    if (ld) m_idx = src ? dat : 16'(PE_ID);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check_now();                         // R8 reset value 0 while held in reset
    rst_ni = 1'b1;
    // R1 literals
    vec(3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0, '0);
    vec(3'd0, 1'b0, 64'h8000_0000_0000_0001, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0, '0);
    // R2 unindexed, then R8 load element number (R10: 6-bit id zero-extended)
    vec(3'd1, 1'b0, 64'hABCD_0000_0000_1234, '0, '0, 1'b0, 2'd0, 1'b1, 1'b0, 16'hFFFF);
    vec(3'd1, 1'b1, 64'h0000_0000_0000_1234, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0, '0);
    vec(3'd1, 1'b1, 64'h0000_0000_0000_FFFF, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0, '0); // R2 wrap
    // R3 ignores indexing
    vec(3'd2, 1'b1, 64'h1111_2222_3333_00F7, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0, '0);
    // R4/R5 distances 0, 127, wrap 100+37
    vec(3'd3, 1'b0, 64'h0, 64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_FEDC_BA98, 1'b1, 2'd0, 1'b0, 1'b0, '0);
    vec(3'd3, 1'b0, 64'h7F, 64'h1, 64'h0, 1'b1, 2'd0, 1'b0, 1'b0, '0);
    vec(3'd3, 1'b0, 64'h7F, 64'h0, 64'h8000_0000_0000_0000, 1'b0, 2'd0, 1'b0, 1'b0, '0);
    vec(3'd3, 1'b1, 64'd100, 64'hF0F0_F0F0_F0F0_F0F0, 64'h1234_5678_9ABC_DEF0, 1'b1, 2'd0, 1'b0, 1'b0, '0);
    vec(3'd3, 1'b1, 64'd27, 64'hF0F0_F0F0_F0F0_F0F0, 64'h1234_5678_9ABC_DEF0, 1'b0, 2'd0, 1'b0, 1'b0, '0);
    // R6/R7 bit ops, number 60+37 wraps to 33
    for (int op = 0; op < 4; op++)
      vec(3'd4, 1'b1, 64'd60, 64'h0000_0002_5555_AAAA, '0, 1'b0, 2'(op), 1'b0, 1'b0, '0);
    vec(3'd4, 1'b0, 64'd63, 64'h8000_0000_0000_0000, '0, 1'b0, 2'd3, 1'b0, 1'b0, '0);
    vec(3'd4, 1'b0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, '0, 1'b0, 2'd1, 1'b0, 1'b0, '0);
    // R8 load from datapath, then hold
    vec(3'd1, 1'b1, 64'h10, '0, '0, 1'b0, 2'd0, 1'b1, 1'b1, 16'hFFF5);
    vec(3'd1, 1'b1, 64'h10, '0, '0, 1'b0, 2'd0, 1'b0, 1'b1, 16'h0001);
    vec(3'd3, 1'b1, 64'h0, 64'h1, 64'h0, 1'b1, 2'd0, 1'b0, 1'b0, '0);
    // R9 unused variant codes
    for (int v = 5; v < 8; v++)
      vec(3'(v), 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
          64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd3, 1'b0, 1'b0, '0);
    // random sweep over all requirements
    for (int i = 0; i < 400; i++)
      vec(3'($urandom_range(0, 7)), 1'($urandom), {$urandom, $urandom},
          {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 2'($urandom),
          1'($urandom_range(0, 3) == 0), 1'($urandom), 16'($urandom));
    @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule